// File: doc/BRIEF.md
# Partition-Aware Eviction Chooser for a Shared Set-Associative Cache

This block decides which way of one set of a shared cache is replaced when a core misses. It keeps, for every set, a valid bit, the id of the core that filled each line, and the recency rank of each way. Each core has two way quotas: a private quota and a quota in the shared pool. A separate input gives the size of the shared pool. On a miss the block first takes a free way. If the set is full, it takes a line from a core that holds more lines than its two quotas allow. If no core is over its quotas, it takes the oldest line that lies in the shared pool. If that does not apply either, it takes the requester's own oldest line. The victim is then filled for the requester and becomes the most recent line.

Quota changes are applied lazily. A new quota never flushes a line. Lines above a core's new limit are reclaimed one at a time, as later misses in that set choose them. Tag compare and data movement are handled outside the block: the caller says whether the access hit and, on a hit, which way. A combinational peek port shows the stored state of any set, for use by the tag array next to the block.

Top module: `part_victim_sel`

## Requirements
- R1: After reset every line of every set is invalid and has owner 0. Way w holds recency rank w, where rank 0 is the most recent and rank WAYS-1 is the oldest.
- R2: If the requested set has an invalid way, the victim is the lowest-numbered invalid way and victim_reason is 0.
- R3: A core is over quota when the number of valid lines it owns in the set is greater than its private quota plus its shared quota. If the set is full and some core is over quota, the victim is that core's oldest line and victim_reason is 1.
- R4: If more than one core is over quota, the chosen core is the one with the largest excess. On an equal excess the lowest core id wins.
- R5: Number each core's lines in the set from its most recent line, starting at 0. A line is in the shared pool when its number is at least its owner's private quota. If no core is over quota, shared_ways is nonzero and the pool holds at least one line, the victim is the oldest pool line and victim_reason is 2.
- R6: If none of the above applies, the victim is the requester's oldest line and victim_reason is 3. If the requester owns no line in the set, the victim is the oldest line of the set.
- R7: When a miss is accepted (req_valid=1, req_hit=0), the victim becomes valid, its owner becomes req_core and its rank becomes 0. Every line that was more recent than the victim becomes one rank older. All other ranks stay as they were.
- R8: When a hit is accepted (req_valid=1, req_hit=1), way req_hit_way moves to rank 0 and keeps its owner and valid bit. victim_fill is 0 during a hit.
- R9: A quota change alone changes no stored state. It takes effect only in the choices made by later misses.
- R10: victim_way, victim_reason and victim_fill are combinational in the cycle of the request. The stored state changes at the next rising clock edge.
- R11: Quotas are packed so that core c uses bits [c*QW +: QW] of quota_priv and quota_shr. On the peek port, way w uses bit w of peek_valid, bits [w*CW +: CW] of peek_owner and bits [w*WW +: WW] of peek_rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_hit | input | 1 | 1 for a hit, 0 for a miss |
| req_set | input | SW | Set index of the access |
| req_core | input | CW | Requesting core id |
| req_hit_way | input | WW | Way that hit (used only on a hit) |
| quota_priv | input | CORES*QW | Private way quota of each core |
| quota_shr | input | CORES*QW | Shared-pool way quota of each core |
| shared_ways | input | QW | Size of the shared pool; 0 means no pool |
| victim_fill | output | 1 | A miss is being served this cycle |
| victim_way | output | WW | Way chosen for replacement |
| victim_reason | output | 2 | Why the way was chosen: 0 free, 1 over quota, 2 pool, 3 own/oldest |
| peek_set | input | SW | Set shown on the peek port |
| peek_valid | output | WAYS | Valid bits of the peeked set |
| peek_owner | output | WAYS*CW | Owner ids of the peeked set |
| peek_rank | output | WAYS*WW | Recency ranks of the peeked set |

## Verification
The bound checker tests several rules on every miss and hit:
- a free way is always taken before a valid one;
- an over-quota victim really belongs to a core above its combined limit;
- a pool victim only appears when the pool is nonzero;
- a private victim belongs to the requester, unless the requester owns nothing in the set;
- a fill or a hit leaves the touched way at rank 0 with the correct owner.

Some behaviour is visible only through the directed scenarios, because it depends on a history of accesses:
- which line is the oldest one;
- the tie-break between over-quota cores;
- lazy reclaiming after a quota cut;
- the fallback when the requester owns no lines.

// File: rtl/pvs_pkg.sv
package pvs_pkg;
  typedef enum logic [1:0] {
    VR_FREE = 2'd0,
    VR_OVER = 2'd1,
    VR_POOL = 2'd2,
    VR_OWN  = 2'd3
  } vreason_e;
endpackage

// File: rtl/pvs_census.sv
module pvs_census #(
  parameter int WAYS  = 16,
  parameter int CORES = 2,
  localparam int CW = (CORES > 1) ? $clog2(CORES) : 1,
  localparam int QW = $clog2(WAYS + 1)
) (
  input  logic [WAYS-1:0]            line_vld,
  input  logic [WAYS-1:0][CW-1:0]    line_own,
  input  logic [CORES-1:0][QW-1:0]   cap_priv,
  input  logic [CORES-1:0][QW-1:0]   cap_shr,
  output logic [CORES-1:0][QW-1:0]   held,
  output logic                       over_any,
  output logic [CW-1:0]              over_core
);
  // Amount by which a core exceeds its combined limit, 0 when within it.
  function automatic logic [QW:0] excess_of(input logic [QW-1:0] cnt,
                                            input logic [QW-1:0] p,
                                            input logic [QW-1:0] s);
    logic [QW:0] lim;
    lim = {1'b0, p} + {1'b0, s};
    return ({1'b0, cnt} > lim) ? ({1'b0, cnt} - lim) : '0;
  endfunction

  always_comb begin
    for (int c = 0; c < CORES; c++) begin
      held[c] = '0;
      for (int w = 0; w < WAYS; w++)
        if (line_vld[w] && line_own[w] == CW'(c)) held[c] = held[c] + 1'b1;
    end
  end

  logic [QW:0] best_ex;
  always_comb begin
    best_ex   = '0;
    over_core = '0;
    for (int c = 0; c < CORES; c++) begin
      // strict compare keeps the lowest id on a tie
      if (excess_of(held[c], cap_priv[c], cap_shr[c]) > best_ex) begin
        best_ex   = excess_of(held[c], cap_priv[c], cap_shr[c]);
        over_core = CW'(c);
      end
    end
    over_any = (best_ex != '0);
  end
endmodule

// File: rtl/pvs_select.sv
module pvs_select
  import pvs_pkg::*;
#(
  parameter int WAYS  = 16,
  parameter int CORES = 2,
  localparam int CW = (CORES > 1) ? $clog2(CORES) : 1,
  localparam int QW = $clog2(WAYS + 1),
  localparam int WW = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            line_vld,
  input  logic [WAYS-1:0][CW-1:0]    line_own,
  input  logic [WAYS-1:0][WW-1:0]    line_rank,
  input  logic [CW-1:0]              req_core,
  input  logic [CORES-1:0][QW-1:0]   cap_priv,
  input  logic [QW-1:0]              pool_ways,
  input  logic                       over_any,
  input  logic [CW-1:0]              over_core,
  output logic [WW-1:0]              victim_way,
  output vreason_e                   victim_why
);
  // Oldest way among the masked ways: {found, way}.
  function automatic logic [WW:0] oldest(input logic [WAYS-1:0] m,
                                         input logic [WAYS-1:0][WW-1:0] r);
    logic          found;
    logic [WW-1:0] way;
    logic [WW-1:0] best;
    found = 1'b0;
    way   = '0;
    best  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (m[w] && (!found || r[w] > best)) begin
        found = 1'b1;
        way   = WW'(w);
        best  = r[w];
      end
    end
    return {found, way};
  endfunction

  // Position of each line among the lines of its own owner, 0 = most recent.
  logic [WAYS-1:0][QW-1:0] peer_rank;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      peer_rank[w] = '0;
      for (int v = 0; v < WAYS; v++)
        if (line_vld[v] && line_own[v] == line_own[w] && line_rank[v] < line_rank[w])
          peer_rank[w] = peer_rank[w] + 1'b1;
    end
  end

  logic [WAYS-1:0] pool_mask, over_mask, own_mask;
  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      pool_mask[w] = line_vld[w] && (peer_rank[w] >= cap_priv[line_own[w]]);
      over_mask[w] = line_vld[w] && (line_own[w] == over_core);
      own_mask[w]  = line_vld[w] && (line_own[w] == req_core);
    end
  end

  logic          has_free;
  logic [WW-1:0] free_way;
  always_comb begin
    has_free = ~&line_vld;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!line_vld[w]) free_way = WW'(w);
  end

  logic [WW:0] pick_over, pick_pool, pick_own, pick_any;
  assign pick_over = oldest(over_mask, line_rank);
  assign pick_pool = oldest(pool_mask, line_rank);
  assign pick_own  = oldest(own_mask, line_rank);
  assign pick_any  = oldest(line_vld, line_rank);

  always_comb begin
    if (has_free) begin
      victim_way = free_way;
      victim_why = VR_FREE;
    end else if (over_any) begin
      victim_way = pick_over[WW-1:0];
      victim_why = VR_OVER;
    end else if (pool_ways != '0 && pick_pool[WW]) begin
      victim_way = pick_pool[WW-1:0];
      victim_why = VR_POOL;
    end else if (pick_own[WW]) begin
      victim_way = pick_own[WW-1:0];
      victim_why = VR_OWN;
    end else begin
      victim_way = pick_any[WW-1:0];
      victim_why = VR_OWN;
    end
  end
endmodule

// File: rtl/pvs_age.sv
module pvs_age #(
  parameter int WAYS = 16,
  localparam int WW = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][WW-1:0] rank_in,
  input  logic [WW-1:0]           touch_way,
  output logic [WAYS-1:0][WW-1:0] rank_out
);
  // Move the touched way to rank 0; the lines that were more recent age by one.
  function automatic logic [WW-1:0] age_step(input logic [WW-1:0] mine,
                                             input logic [WW-1:0] pivot,
                                             input logic          is_touched);
    if (is_touched) return '0;
    if (mine < pivot) return mine + 1'b1;
    return mine;
  endfunction

  logic [WW-1:0] pivot;
  assign pivot = rank_in[touch_way];

  for (genvar w = 0; w < WAYS; w++) begin : g_age
    assign rank_out[w] = age_step(rank_in[w], pivot, touch_way == WW'(w));
  end
endmodule

// File: rtl/part_victim_sel.sv
module part_victim_sel
  import pvs_pkg::*;
#(
  parameter int WAYS  = 16,
  parameter int CORES = 2,
  parameter int SETS  = 8,
  localparam int CW = (CORES > 1) ? $clog2(CORES) : 1,
  localparam int QW = $clog2(WAYS + 1),
  localparam int WW = $clog2(WAYS),
  localparam int SW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_hit,
  input  logic [SW-1:0]         req_set,
  input  logic [CW-1:0]         req_core,
  input  logic [WW-1:0]         req_hit_way,
  input  logic [CORES*QW-1:0]   quota_priv,
  input  logic [CORES*QW-1:0]   quota_shr,
  input  logic [QW-1:0]         shared_ways,
  output logic                  victim_fill,
  output logic [WW-1:0]         victim_way,
  output logic [1:0]            victim_reason,
  input  logic [SW-1:0]         peek_set,
  output logic [WAYS-1:0]       peek_valid,
  output logic [WAYS*CW-1:0]    peek_owner,
  output logic [WAYS*WW-1:0]    peek_rank
);
  logic [SETS-1:0][WAYS-1:0]          vld_q;
  logic [SETS-1:0][WAYS-1:0][CW-1:0]  own_q;
  logic [SETS-1:0][WAYS-1:0][WW-1:0]  rank_q;

  logic [CORES-1:0][QW-1:0] cap_priv, cap_shr, held;
  assign cap_priv = quota_priv;
  assign cap_shr  = quota_shr;

  // Named events for the checker
  logic miss_evt, hit_evt;
  assign miss_evt = req_valid && !req_hit;
  assign hit_evt  = req_valid && req_hit;

  logic [WAYS-1:0]          cur_vld;
  logic [WAYS-1:0][CW-1:0]  cur_own;
  logic [WAYS-1:0][WW-1:0]  cur_rank, nxt_rank;
  assign cur_vld  = vld_q[req_set];
  assign cur_own  = own_q[req_set];
  assign cur_rank = rank_q[req_set];

  logic          over_any;
  logic [CW-1:0] over_core;
  vreason_e      why;
  logic [WW-1:0] pick_way, touch_way;

  pvs_census #(.WAYS(WAYS), .CORES(CORES)) u_census (
    .line_vld (cur_vld),
    .line_own (cur_own),
    .cap_priv (cap_priv),
    .cap_shr  (cap_shr),
    .held     (held),
    .over_any (over_any),
    .over_core(over_core)
  );

  pvs_select #(.WAYS(WAYS), .CORES(CORES)) u_select (
    .line_vld  (cur_vld),
    .line_own  (cur_own),
    .line_rank (cur_rank),
    .req_core  (req_core),
    .cap_priv  (cap_priv),
    .pool_ways (shared_ways),
    .over_any  (over_any),
    .over_core (over_core),
    .victim_way(pick_way),
    .victim_why(why)
  );

  assign touch_way = req_hit ? req_hit_way : pick_way;

  pvs_age #(.WAYS(WAYS)) u_age (
    .rank_in  (cur_rank),
    .touch_way(touch_way),
    .rank_out (nxt_rank)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        own_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) rank_q[s][w] <= WW'(w);
      end
    end else if (req_valid) begin
      rank_q[req_set] <= nxt_rank;
      if (!req_hit) begin
        vld_q[req_set][pick_way] <= 1'b1;
        own_q[req_set][pick_way] <= req_core;
      end
    end
  end

  assign victim_fill   = miss_evt;
  assign victim_way    = pick_way;
  assign victim_reason = why;

  assign peek_valid = vld_q[peek_set];
  assign peek_owner = own_q[peek_set];
  assign peek_rank  = rank_q[peek_set];
endmodule

// File: rtl/pvs_checker.sv
module pvs_checker #(
  parameter int WAYS  = 16,
  parameter int CORES = 2,
  parameter int SETS  = 8,
  localparam int CW = (CORES > 1) ? $clog2(CORES) : 1,
  localparam int QW = $clog2(WAYS + 1),
  localparam int WW = $clog2(WAYS),
  localparam int SW = (SETS > 1) ? $clog2(SETS) : 1
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              miss_evt,
  input logic                              hit_evt,
  input logic [SW-1:0]                     req_set,
  input logic [CW-1:0]                     req_core,
  input logic [WW-1:0]                     req_hit_way,
  input logic [WW-1:0]                     victim_way,
  input logic [1:0]                        victim_reason,
  input logic [WAYS-1:0]                   cur_vld,
  input logic [WAYS-1:0][CW-1:0]           cur_own,
  input logic [CORES-1:0][QW-1:0]          held,
  input logic [CORES-1:0][QW-1:0]          cap_priv,
  input logic [CORES-1:0][QW-1:0]          cap_shr,
  input logic [QW-1:0]                     shared_ways,
  input logic [SETS-1:0][WAYS-1:0]         vld_q,
  input logic [SETS-1:0][WAYS-1:0][CW-1:0] own_q,
  input logic [SETS-1:0][WAYS-1:0][WW-1:0] rank_q
);
  assert_free_way_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && !(&cur_vld)) |-> (!cur_vld[victim_way] && victim_reason == 2'd0));

  assert_over_owner_exceeds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && victim_reason == 2'd1) |->
      ({1'b0, held[cur_own[victim_way]]} >
       ({1'b0, cap_priv[cur_own[victim_way]]} + {1'b0, cap_shr[cur_own[victim_way]]})));

  assert_pool_needs_ways_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && victim_reason == 2'd2) |-> (shared_ways != '0 && (&cur_vld)));

  assert_own_or_oldest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && victim_reason == 2'd3) |->
      (cur_own[victim_way] == req_core || held[req_core] == '0));

  assert_fill_mru_R7: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> (vld_q[$past(req_set)][$past(victim_way)] &&
                  own_q[$past(req_set)][$past(victim_way)] == $past(req_core) &&
                  rank_q[$past(req_set)][$past(victim_way)] == '0));

  assert_hit_keeps_owner_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> (own_q[$past(req_set)][$past(req_hit_way)] == $past(own_q[req_set][req_hit_way]) &&
                 rank_q[$past(req_set)][$past(req_hit_way)] == '0));
endmodule

bind part_victim_sel pvs_checker #(.WAYS(WAYS), .CORES(CORES), .SETS(SETS)) u_pvs_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .miss_evt     (miss_evt),
  .hit_evt      (hit_evt),
  .req_set      (req_set),
  .req_core     (req_core),
  .req_hit_way  (req_hit_way),
  .victim_way   (victim_way),
  .victim_reason(victim_reason),
  .cur_vld      (cur_vld),
  .cur_own      (cur_own),
  .held         (held),
  .cap_priv     (cap_priv),
  .cap_shr      (cap_shr),
  .shared_ways  (shared_ways),
  .vld_q        (vld_q),
  .own_q        (own_q),
  .rank_q       (rank_q)
);

// File: tb/part_victim_sel_test.sv
module part_victim_sel_test;
  localparam int WAYS = 16, CORES = 2, SETS = 8;
  localparam int CW = 1, QW = 5, WW = 4, SW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_hit = 1'b0;
  logic [SW-1:0] req_set = '0;
  logic [CW-1:0] req_core = '0;
  logic [WW-1:0] req_hit_way = '0;
  logic [CORES*QW-1:0] quota_priv = '0, quota_shr = '0;
  logic [QW-1:0] shared_ways = '0;
  logic victim_fill;
  logic [WW-1:0] victim_way;
  logic [1:0] victim_reason;
  logic [SW-1:0] peek_set = '0;
  logic [WAYS-1:0] peek_valid;
  logic [WAYS*CW-1:0] peek_owner;
  logic [WAYS*WW-1:0] peek_rank;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  part_victim_sel #(.WAYS(WAYS), .CORES(CORES), .SETS(SETS)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_hit(req_hit),
    .req_set(req_set), .req_core(req_core), .req_hit_way(req_hit_way),
    .quota_priv(quota_priv), .quota_shr(quota_shr), .shared_ways(shared_ways),
    .victim_fill(victim_fill), .victim_way(victim_way), .victim_reason(victim_reason),
    .peek_set(peek_set), .peek_valid(peek_valid), .peek_owner(peek_owner),
    .peek_rank(peek_rank)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_quota(input int p0, input int s0, input int p1, input int s1, input int pool);
    @(negedge clk);
    quota_priv  = {QW'(p1), QW'(p0)};
    quota_shr   = {QW'(s1), QW'(s0)};
    shared_ways = QW'(pool);
  endtask

  // Miss: check the victim in the request cycle, then let it fill (R10).
  task automatic miss(input int s, input int c, input int exp_way, input int exp_why, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_hit = 1'b0; req_set = SW'(s); req_core = CW'(c);
    #1;
    check(victim_fill && victim_way == WW'(exp_way), {req, " way"}, victim_way, exp_way);
    check(victim_reason == 2'(exp_why), {req, " reason"}, victim_reason, exp_why);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic hit(input int s, input int c, input int way);
    @(negedge clk);
    req_valid = 1'b1; req_hit = 1'b1; req_set = SW'(s); req_core = CW'(c); req_hit_way = WW'(way);
    #1;
    check(!victim_fill, "R8 no fill on hit", victim_fill, 0);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic peek(input int s, input int w, input int ev, input int eo, input int er, input string req);
    @(negedge clk);
    peek_set = SW'(s);
    #1;
    check(peek_valid[w] == ev[0], {req, " valid"}, peek_valid[w], ev);
    check(peek_owner[w*CW +: CW] == CW'(eo), {req, " owner"}, peek_owner[w*CW +: CW], eo);
    check(peek_rank[w*WW +: WW] == WW'(er), {req, " rank"}, peek_rank[w*WW +: WW], er);
  endtask

  task automatic fill_half(input int s);
    for (int i = 0; i < 16; i++) miss(s, (i < 8) ? 0 : 1, i, 0, "R2 fill free way");
  endtask

  task automatic t_reset;
    peek(0, 5, 0, 0, 5, "R1 reset way5");
    peek(7, 15, 0, 0, 15, "R1 reset set7 way15");
  endtask

  task automatic t_private_and_lazy;
    set_quota(8, 0, 8, 0, 0);
    fill_half(0);
    peek(0, 0, 1, 0, 15, "R7 oldest after fill");
    peek(0, 15, 1, 1, 0, "R7 newest after fill");
    miss(0, 0, 0, 3, "R6 own oldest core0");
    miss(0, 1, 8, 3, "R6 own oldest core1");
    peek(0, 8, 1, 1, 0, "R7 refill mru");
    peek(0, 1, 1, 0, 15, "R7 aging");
    set_quota(6, 0, 10, 0, 0);
    peek(0, 8, 1, 1, 0, "R9 quota change no state effect");
    peek(0, 1, 1, 0, 15, "R9 quota change keeps owner");
    miss(0, 1, 1, 1, "R3 lazy reclaim first");
    miss(0, 1, 2, 1, "R3 lazy reclaim second");
    miss(0, 1, 9, 3, "R6 after reclaim done");
  endtask

  task automatic t_tie;
    set_quota(8, 0, 8, 0, 0);
    fill_half(2);
    set_quota(6, 0, 6, 0, 0);
    miss(2, 1, 0, 1, "R4 tie lowest core");
    miss(2, 0, 8, 1, "R4 largest excess");
  endtask

  task automatic t_pool;
    set_quota(4, 4, 4, 4, 8);
    fill_half(3);
    miss(3, 1, 0, 2, "R5 pool oldest");
    miss(3, 0, 8, 1, "R3 over after pool fill");
    miss(3, 1, 1, 2, "R5 pool by owner position");
    hit(3, 1, 5);
    peek(3, 5, 1, 0, 0, "R8 hit keeps owner");
    peek(3, 1, 1, 1, 1, "R8 hit ages newer");
  endtask

  task automatic t_fallback;
    set_quota(16, 0, 0, 0, 0);
    for (int i = 0; i < 16; i++) miss(4, 0, i, 0, "R2 fill set4");
    miss(4, 1, 0, 3, "R6 requester owns none");
    peek(4, 0, 1, 1, 0, "R11 peek owner field");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_private_and_lazy();
    t_tie();
    t_pool();
    t_fallback();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule